// File: doc/BRIEF.md
# External Conversion Trigger Qualifier

This block sits between an asynchronous trigger pin and a conversion sequencer. It brings the pin into the peripheral clock domain through a chain of synchronising flops. It then measures how long the synchronised value has been stable. When the programmed condition is met and hardware triggering is enabled, it raises a single-cycle start pulse. The condition is one of two levels or one of two edges.

The same block holds the sequencer's start bit. The bit can be set by a qualified hardware request, written to either value by software, or cleared by the sequencer when a sequence completes. A software write always decides the bit in its own cycle. A hardware request arriving in that cycle is dropped. Each write of the condition field restarts the stability measurement. A held level therefore produces exactly one request, and a new request needs the pin to leave the active level and come back.

Top module: `xtrig_qualifier`

## Requirements
- R1: Out of reset, `start_pulse` and `start_bit` are 0. The pin passes through `SYNC_STAGES` (default 2) flops before it is filtered.
- R2: `cond_sel` selects the condition: 2'b00 low level, 2'b01 high level, 2'b10 falling edge, 2'b11 rising edge.
- R3: A level condition qualifies once the synchronised pin has held the active value for `LEVEL_HOLD` (default 8) consecutive samples. With default parameters, `start_pulse` is high in the 10th cycle after the pin changes.
- R4: A level that stays active produces exactly one pulse. A further pulse requires the pin to leave the active level and then qualify again.
- R5: An edge condition qualifies only when two things hold: the pin held the old value for at least `EDGE_HOLD` (default 4) samples, and it holds the new value for `EDGE_HOLD` samples. With default parameters, the pulse is high in the 6th cycle after the pin changes.
- R6: A pin excursion shorter than the required hold time produces no pulse.
- R7: While `trig_en` is 0, no pulse is produced and `start_bit` is not set by the pin.
- R8: In a cycle with `sw_wr` high, `start_bit` takes `sw_val` on the next edge and any hardware request in that cycle is discarded.
- R9: With no software write, a hardware request sets `start_bit`, even when `seq_done` is high in the same cycle. Otherwise `seq_done` clears `start_bit`.
- R10: A cycle with `cond_wr` high discards any qualification in that cycle and restarts the stability measurement from zero.
- R11: `start_pulse` is never high for two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trig_pin | input | 1 | Asynchronous external trigger pin |
| trig_en | input | 1 | Hardware trigger enable |
| cond_sel | input | 2 | Trigger condition select |
| cond_wr | input | 1 | Strobe: condition field is being written |
| sw_wr | input | 1 | Strobe: software writes the start bit |
| sw_val | input | 1 | Value written by software to the start bit |
| seq_done | input | 1 | Sequencer end-of-sequence, clears the start bit |
| start_pulse | output | 1 | One-cycle qualified hardware start request |
| start_bit | output | 1 | Sequencer start bit |

## Verification
A pin change moves through two synchronising flops and one sample register. It then needs the hold count in further edges. As a result, a level pulse is due 10 cycles after the pin changes and an edge pulse 6 cycles after. Both outputs are registered, so the effect of a software write or of `seq_done` shows one cycle after the strobe. The bench drives inputs on the falling edge and advances its behavioural model on the rising edge. It compares both outputs with the model on every following falling edge. It also counts falling edges from a pin change to the pulse and checks those counts against 10, 6, and 15 when the condition is rewritten mid-count.

// File: rtl/xtrig_pkg.sv
package xtrig_pkg;
  typedef enum logic [1:0] {
    COND_LOW  = 2'b00,
    COND_HIGH = 2'b01,
    COND_FALL = 2'b10,
    COND_RISE = 2'b11
  } xtrig_cond_e;
endpackage

// File: rtl/xtrig_sync.sv
module xtrig_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  generate
    if (STAGES == 1) begin : g_one
      always_comb chain_d = din;
    end else begin : g_many
      always_comb chain_d = {chain_q[STAGES-2:0], din};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/xtrig_filter.sv
module xtrig_filter #(
  parameter int LEVEL_HOLD = 8,
  parameter int EDGE_HOLD  = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic smp,
  input  logic clr,
  output logic level_hit,
  output logic edge_hit,
  output logic cur_val
);
  localparam int CW = $clog2(LEVEL_HOLD + 1);
  localparam logic [CW-1:0] LVL_LAST = CW'(LEVEL_HOLD - 1);
  localparam logic [CW-1:0] EDG_LAST = CW'(EDGE_HOLD - 1);
  localparam logic [CW-1:0] LVL_MAX  = CW'(LEVEL_HOLD);
  localparam logic [CW-1:0] EDG_MIN  = CW'(EDGE_HOLD);

  logic          prev_q, prev_d;
  logic [CW-1:0] run_q, run_d;
  logic          prior_ok_q, prior_ok_d;
  logic          same;

  always_comb begin
    same       = (smp == prev_q);
    prev_d     = smp;
    run_d      = run_q;
    prior_ok_d = prior_ok_q;
    if (clr) begin
      run_d      = '0;
      prior_ok_d = 1'b0;
    end else if (!same) begin
      run_d      = CW'(1);
      prior_ok_d = (run_q >= EDG_MIN);
    end else if (run_q != LVL_MAX) begin
      run_d      = run_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q     <= 1'b0;
      run_q      <= '0;
      prior_ok_q <= 1'b0;
    end else begin
      prev_q     <= prev_d;
      run_q      <= run_d;
      prior_ok_q <= prior_ok_d;
    end
  end

  assign level_hit = !clr && same && (run_q == LVL_LAST);
  assign edge_hit  = !clr && same && prior_ok_q && (run_q == EDG_LAST);
  assign cur_val   = smp;
endmodule

// File: rtl/xtrig_match.sv
module xtrig_match
  import xtrig_pkg::*;
(
  input  logic        enable,
  input  logic [1:0]  cond_sel,
  input  logic        level_hit,
  input  logic        edge_hit,
  input  logic        cur_val,
  output logic        hit
);
  xtrig_cond_e cond;
  logic        raw;

  always_comb begin
    cond = xtrig_cond_e'(cond_sel);
    unique case (cond)
      COND_LOW:  raw = level_hit && !cur_val;
      COND_HIGH: raw = level_hit &&  cur_val;
      COND_FALL: raw = edge_hit  && !cur_val;
      COND_RISE: raw = edge_hit  &&  cur_val;
      default:   raw = 1'b0;
    endcase
    hit = enable && raw;
  end
endmodule

// File: rtl/xtrig_qualifier.sv
module xtrig_qualifier #(
  parameter int SYNC_STAGES = 2,
  parameter int LEVEL_HOLD  = 8,
  parameter int EDGE_HOLD   = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       trig_pin,
  input  logic       trig_en,
  input  logic [1:0] cond_sel,
  input  logic       cond_wr,
  input  logic       sw_wr,
  input  logic       sw_val,
  input  logic       seq_done,
  output logic       start_pulse,
  output logic       start_bit
);
  logic pin_s;
  logic level_hit, edge_hit, cur_val;
  logic hw_req;
  logic pulse_q, pulse_d;
  logic start_q, start_d;

  xtrig_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (trig_pin),
    .dout (pin_s)
  );

  xtrig_filter #(.LEVEL_HOLD(LEVEL_HOLD), .EDGE_HOLD(EDGE_HOLD)) u_filt (
    .clk      (clk),
    .rst_n    (rst_n),
    .smp      (pin_s),
    .clr      (cond_wr),
    .level_hit(level_hit),
    .edge_hit (edge_hit),
    .cur_val  (cur_val)
  );

  xtrig_match u_match (
    .enable   (trig_en),
    .cond_sel (cond_sel),
    .level_hit(level_hit),
    .edge_hit (edge_hit),
    .cur_val  (cur_val),
    .hit      (hw_req)
  );

  always_comb begin
    pulse_d = hw_req && !sw_wr;
    if (sw_wr)         start_d = sw_val;
    else if (hw_req)   start_d = 1'b1;
    else if (seq_done) start_d = 1'b0;
    else               start_d = start_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pulse_q <= 1'b0;
      start_q <= 1'b0;
    end else begin
      pulse_q <= pulse_d;
      start_q <= start_d;
    end
  end

  assign start_pulse = pulse_q;
  assign start_bit   = start_q;
endmodule

// File: rtl/xtrig_qualifier_chk.sv
module xtrig_qualifier_chk (
  input logic clk,
  input logic rst_n,
  input logic trig_en,
  input logic cond_wr,
  input logic sw_wr,
  input logic sw_val,
  input logic seq_done,
  input logic hw_req,
  input logic start_pulse,
  input logic start_bit
);
  a_r11_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    start_pulse |=> !start_pulse);

  a_r7_gated_off: assert property (@(posedge clk) disable iff (!rst_n)
    !trig_en |=> !start_pulse);

  a_r8_sw_wins: assert property (@(posedge clk) disable iff (!rst_n)
    sw_wr |=> (start_bit == $past(sw_val)) && !start_pulse);

  a_r9_pulse_sets: assert property (@(posedge clk) disable iff (!rst_n)
    start_pulse |-> start_bit);

  a_r9_done_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_done && !sw_wr && !hw_req) |=> !start_bit);

  a_r10_cond_write: assert property (@(posedge clk) disable iff (!rst_n)
    cond_wr |=> !start_pulse);
endmodule

bind xtrig_qualifier xtrig_qualifier_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .trig_en    (trig_en),
  .cond_wr    (cond_wr),
  .sw_wr      (sw_wr),
  .sw_val     (sw_val),
  .seq_done   (seq_done),
  .hw_req     (hw_req),
  .start_pulse(start_pulse),
  .start_bit  (start_bit)
);

// File: tb/tb_xtrig_qualifier.sv
module tb_xtrig_qualifier;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       rst_n, trig_pin, trig_en, cond_wr, sw_wr, sw_val, seq_done;
  logic [1:0] cond_sel;
  logic       start_pulse, start_bit;

  xtrig_qualifier dut (
    .clk(clk), .rst_n(rst_n), .trig_pin(trig_pin), .trig_en(trig_en),
    .cond_sel(cond_sel), .cond_wr(cond_wr), .sw_wr(sw_wr), .sw_val(sw_val),
    .seq_done(seq_done), .start_pulse(start_pulse), .start_bit(start_bit)
  );

  int checks = 0;
  int fails  = 0;
  int pcnt   = 0;
  string cur_req = "R1";

  // behavioural reference
  logic m_s1, m_s2, m_prev, m_prior, m_pulse, m_start;
  int   m_run;
  logic m_same, m_lh, m_eh, m_hit;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 <= 0; m_s2 <= 0; m_prev <= 0; m_prior <= 0;
      m_pulse <= 0; m_start <= 0; m_run <= 0;
    end else begin
      m_same = (m_s2 == m_prev);
      m_lh = !cond_wr && m_same && (m_run == 7);
      m_eh = !cond_wr && m_same && m_prior && (m_run == 3);
      case (cond_sel)
        2'b00: m_hit = m_lh && !m_s2;
        2'b01: m_hit = m_lh &&  m_s2;
        2'b10: m_hit = m_eh && !m_s2;
        default: m_hit = m_eh && m_s2;
      endcase
      m_hit = m_hit && trig_en;
      m_pulse <= m_hit && !sw_wr;
      m_start <= sw_wr ? sw_val : (m_hit ? 1'b1 : (seq_done ? 1'b0 : m_start));
      if (cond_wr) begin
        m_run <= 0; m_prior <= 0;
      end else if (!m_same) begin
        m_run <= 1; m_prior <= (m_run >= 4);
      end else if (m_run < 8) begin
        m_run <= m_run + 1;
      end
      m_prev <= m_s2; m_s2 <= m_s1; m_s1 <= trig_pin;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      chk({cur_req, " R11 pulse vs model"}, int'(start_pulse), int'(m_pulse));
      chk({cur_req, " start_bit vs model"}, int'(start_bit), int'(m_start));
    end
  end

  task automatic run(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (start_pulse) pcnt++;
    end
  endtask

  task automatic meas(output int lat);
    lat = 0;
    do begin
      @(negedge clk);
      lat++;
    end while (!start_pulse && lat < 40);
  endtask

  task automatic write_cond(input logic [1:0] c);
    cond_sel = c; cond_wr = 1'b1;
    @(negedge clk);
    cond_wr = 1'b0;
  endtask

  int lat;

  initial begin
    #(20 * 200000);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 0; trig_pin = 0; trig_en = 1; cond_sel = 2'b01; cond_wr = 0;
    sw_wr = 0; sw_val = 0; seq_done = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 reset pulse", int'(start_pulse), 0);
    chk("R1 reset start_bit", int'(start_bit), 0);

    // R3 high level latency, R4 hold and re-arm
    cur_req = "R3";
    pcnt = 0; run(20);
    chk("R2 low pin under high-level cond", pcnt, 0);
    trig_pin = 1; meas(lat);
    chk("R3 level latency", lat, 10);
    cur_req = "R4";
    pcnt = 0; run(30);
    chk("R4 held level no retrigger", pcnt, 0);
    trig_pin = 0; run(12);
    trig_pin = 1; meas(lat);
    chk("R4 rearm latency", lat, 10);

    // R6 glitch
    cur_req = "R6";
    trig_pin = 0; run(12);
    pcnt = 0; trig_pin = 1; run(5); trig_pin = 0; run(15);
    chk("R6 short high rejected", pcnt, 0);

    // R2 low level
    cur_req = "R2";
    trig_pin = 1; run(12);
    write_cond(2'b00); run(5);
    trig_pin = 0; meas(lat);
    chk("R2 low level latency", lat, 10);

    // R5 falling edge
    cur_req = "R5";
    trig_pin = 1; run(12);
    write_cond(2'b10); run(12);
    trig_pin = 0; meas(lat);
    chk("R5 falling latency", lat, 6);
    run(12);
    pcnt = 0; trig_pin = 1; run(2); trig_pin = 0; run(15);
    chk("R5 short prior high rejected", pcnt, 0);
    trig_pin = 1; run(12);
    pcnt = 0; trig_pin = 0; run(2); trig_pin = 1; run(15);
    chk("R5 short low after edge rejected", pcnt, 0);

    // R2 rising edge
    cur_req = "R2";
    write_cond(2'b11); run(12);
    trig_pin = 0; run(12);
    trig_pin = 1; meas(lat);
    chk("R2 rising latency", lat, 6);
    run(5);

    // R9 done clears
    cur_req = "R9";
    seq_done = 1; @(negedge clk); seq_done = 0;
    chk("R9 seq_done clears", int'(start_bit), 0);

    // R7 disabled
    cur_req = "R7";
    write_cond(2'b01); trig_en = 0;
    trig_pin = 0; run(12);
    pcnt = 0; trig_pin = 1; run(20);
    chk("R7 no pulse when disabled", pcnt, 0);
    chk("R7 start_bit unchanged", int'(start_bit), 0);
    trig_en = 1;

    // R8 software priority
    cur_req = "R8";
    trig_pin = 0; run(12);
    sw_wr = 1; sw_val = 0;
    pcnt = 0; trig_pin = 1; run(20);
    chk("R8 hw request dropped under sw write", pcnt, 0);
    chk("R8 start_bit follows sw", int'(start_bit), 0);
    sw_val = 1; @(negedge clk);
    chk("R8 sw sets start_bit", int'(start_bit), 1);
    sw_val = 0; @(negedge clk);
    chk("R8 sw clears start_bit", int'(start_bit), 0);
    sw_wr = 0;

    // R9 hw beats done
    cur_req = "R9";
    trig_pin = 0; run(12);
    seq_done = 1; trig_pin = 1; meas(lat);
    chk("R9 latency with done held", lat, 10);
    chk("R9 hw request beats done", int'(start_bit), 1);
    @(negedge clk);
    chk("R9 done clears after pulse", int'(start_bit), 0);
    seq_done = 0;

    // R10 condition write restarts filter
    cur_req = "R10";
    trig_pin = 0; run(12);
    trig_pin = 1; run(6);
    write_cond(2'b01);
    lat = 7;
    do begin
      @(negedge clk); lat++;
    end while (!start_pulse && lat < 40);
    chk("R10 restarted latency", lat, 15);

    run(5);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule